// File: doc/BRIEF.md
# Dual-law serial clock tick generator

This block turns a module clock into the toggle ticks that a SPI shift engine uses to flip its serial clock. A single configuration register picks one of two divide laws. Under the linear law an 8-bit field N gives a serial clock of the module clock over 2·(N+1). Under the exponential law a 4-bit field M gives the module clock over 2^(M+1). Software works out which law and which value it needs. The linear law is the natural pick while the needed divisor fits in 256 half-periods, and the exponential law covers slower rates beyond that. A linear setting with N=0 gives the fastest serial clock, half the module clock.

The transfer engine holds `run_en` high for as long as it wants serial-clock edges. Each `sck_tick` pulse marks one half-period boundary, so the engine toggles its serial clock on every tick. The half-period counter is cleared whenever `run_en` is low or the register is written. This makes the first half-period after a start or a reconfiguration full length.

Top module: `sck_rate_gen`

## Requirements
- R1: After reset the register reads 0, `sck_tick` is low, and the default setting (exponential law, M=0) gives a tick on every module clock once `run_en` is high.
- R2: A write stores bits 7:0 as N, bits 11:8 as M and bit 12 as the law select, and a read returns those 13 bits in the same positions.
- R3: Bits 31:13 of the register always read as zero, and writing ones to them changes nothing.
- R4: With bit 12 = 1, ticks come every N+1 module clocks: N=0 gives a tick every clock and N=255 gives one every 256 clocks.
- R5: With bit 12 = 0, ticks come every 2^M module clocks, up to 32768 clocks for M=15.
- R6: Changing only bit 12 switches between the two laws while the N and M fields stay the same.
- R7: While `run_en` is low no tick is produced and the count is held at zero. After `run_en` rises, the first tick comes a full half-period later, counting the first clock edge at which `run_en` is high as edge one.
- R8: A register write clears the count and suppresses any tick at that edge. The next tick comes a full new half-period after the write edge.
- R9: When the half-period is longer than one clock, each tick lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| run_en | input | 1 | Run enable from the transfer engine |
| sck_tick | output | 1 | One-clock pulse per serial-clock half-period |

## Verification
A register write and the end of a half-period can land on the same clock edge. The write must then win: it suppresses the tick and restarts the count under the new setting. The bench provokes this by waiting for a tick under a 6-clock half-period and timing a write so that it lands exactly on the edge where the next tick is due. It then judges the result by checking that no tick shows after that edge and that the following tick arrives exactly one new half-period later.

// File: rtl/sck_rate_pkg.sv
package sck_rate_pkg;

    // Width of the linear divisor field and of the exponent field.
    parameter int DIV_W = 8;
    parameter int EXP_W = 4;

    // Longest half-period is 2^(2^EXP_W - 1) clocks, so the counter needs 2^EXP_W bits.
    localparam int POW_CNT_W = 1 << EXP_W;
    localparam int CNT_W     = (POW_CNT_W > DIV_W + 1) ? POW_CNT_W : DIV_W + 1;

    // Register layout: select bit directly above the exponent and divisor fields.
    localparam int SEL_BIT = DIV_W + EXP_W;
    localparam int CFG_W   = SEL_BIT + 1;

    typedef struct packed {
        logic             lin_sel;
        logic [EXP_W-1:0] pow_exp;
        logic [DIV_W-1:0] lin_div;
    } rate_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } div_state_t;

endpackage

// File: rtl/sck_rate_cfg.sv
module sck_rate_cfg
    import sck_rate_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output rate_cfg_t        cfg,
    output logic [REG_W-1:0] rdata
);

    localparam int PAD_W = REG_W - CFG_W;

    rate_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = rate_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg   = cfg_q;
    assign rdata = {{PAD_W{1'b0}}, cfg_q};

    // A write is visible on the read port one edge later, upper bits clear.
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata[CFG_W-1:0] == $past(wdata[CFG_W-1:0])) && (rdata[REG_W-1:CFG_W] == '0));

    // Without a write the register holds its value.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));

endmodule

// File: rtl/sck_rate_limit.sv
module sck_rate_limit
    import sck_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  rate_cfg_t        cfg,
    output logic [CNT_W-1:0] last_cnt
);

    logic [CNT_W-1:0] pow_last;
    logic [CNT_W-1:0] lin_last;

    // Exponential law: last count is 2^M - 1, i.e. M low ones.
    for (genvar i = 0; i < CNT_W; i++) begin : g_pow_mask
        localparam int unsigned IDX = i;
        assign pow_last[i] = ({{(32-EXP_W){1'b0}}, cfg.pow_exp} > IDX);
    end

    // Linear law: last count is N.
    assign lin_last = {{(CNT_W-DIV_W){1'b0}}, cfg.lin_div};

    always_comb begin
        last_cnt = cfg.lin_sel ? lin_last : pow_last;
    end

    // Exponential half-periods are always a power of two.
    p_pow_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.lin_sel |-> ((CNT_W'(last_cnt + 1'b1) & last_cnt) == '0));

    // Linear half-periods never exceed 256 clocks.
    p_lin_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.lin_sel |-> (last_cnt < CNT_W'(1 << DIV_W)));

endmodule

// File: rtl/sck_rate_count.sv
module sck_rate_count
    import sck_rate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             restart,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             tick
);

    div_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!run_en || restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == last_cnt) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!st_q.tick && st_q.cnt == '0));

    p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!st_q.tick && st_q.cnt == '0));

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tick && last_cnt != '0) |=> !st_q.tick);

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !restart && st_q.cnt < last_cnt) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen
    import sck_rate_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             run_en,
    output logic             sck_tick
);

    rate_cfg_t        cfg;
    logic [CNT_W-1:0] last_cnt;

    sck_rate_cfg #(.REG_W(REG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    sck_rate_limit u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .last_cnt (last_cnt)
    );

    sck_rate_count u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .restart  (cfg_we),
        .last_cnt (last_cnt),
        .tick     (sck_tick)
    );

    // A tick is only ever produced from an edge where the engine was running.
    p_tick_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sck_tick |-> $past(run_en));

endmodule

// File: tb/sck_rate_gen_tb.sv
`timescale 1ns/1ps
module sck_rate_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        run_en = 1'b0;
    logic        sck_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sck_rate_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .run_en    (run_en),
        .sck_tick  (sck_tick)
    );

    // Expected half-period in module clocks: bit 12 picks N+1 or 2^M.
    function automatic int exp_len(logic [31:0] v);
        if (v[12]) return int'(v[7:0]) + 1;
        return 1 << v[11:8];
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [31:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sck_tick && n < 40000);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        int len;
        logic [31:0] v;
        void'($urandom(32'd2024));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cfg_rdata == 32'h0, "R1 rdata", cfg_rdata, 0);
        chk(sck_tick == 1'b0, "R1 tick", sck_tick, 0);
        rst_n = 1'b1;

        // R1: default exponential law with M=0 ticks every clock
        @(negedge clk);
        run_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            wait_tick(n);
            chk(n == 1, "R1 default period", n, 1);
        end
        run_en = 1'b0;

        // R3: upper bits ignored, read as zero
        write_cfg(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'h0000_1FFF, "R3 all ones", cfg_rdata, 32'h1FFF);
        write_cfg(32'hA5A5_E3C7);
        chk(cfg_rdata == 32'h0000_03C7, "R3 pattern", cfg_rdata, 32'h03C7);

        // R4: linear N=0 fastest, N=255 slowest
        write_cfg(32'h0000_1000);
        run_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            wait_tick(n);
            chk(n == 1, "R4 N=0", n, 1);
        end
        run_en = 1'b0;
        write_cfg(32'h0000_10FF);
        run_en = 1'b1;
        for (int k = 0; k < 2; k++) begin
            wait_tick(n);
            chk(n == 256, "R4 N=255", n, 256);
        end
        @(negedge clk);
        chk(sck_tick == 1'b0, "R9 N=255 width", sck_tick, 0);
        run_en = 1'b0;

        // R5: exponential M=15
        write_cfg(32'h0000_0F00);
        run_en = 1'b1;
        wait_tick(n);
        chk(n == 32768, "R5 M=15", n, 32768);
        run_en = 1'b0;

        // R6: only the select bit differs
        write_cfg(32'h0000_1304);
        run_en = 1'b1;
        wait_tick(n);
        chk(n == 5, "R6 linear side", n, 5);
        run_en = 1'b0;
        write_cfg(32'h0000_0304);
        run_en = 1'b1;
        wait_tick(n);
        chk(n == 8, "R6 exponential side", n, 8);
        run_en = 1'b0;

        // R2: random settings, read back and periods
        for (int it = 0; it < 14; it++) begin
            v = $urandom;
            v[7:0]  = 8'($urandom % 256);
            v[11:8] = 4'($urandom % 9);
            len = exp_len(v);
            write_cfg(v);
            chk(cfg_rdata == (v & 32'h1FFF), "R2 readback", cfg_rdata, v & 32'h1FFF);
            run_en = 1'b1;
            for (int k = 0; k < 3; k++) begin
                wait_tick(n);
                chk(n == len, v[12] ? "R4 random" : "R5 random", n, len);
            end
            if (len > 1) begin
                @(negedge clk);
                chk(sck_tick == 1'b0, "R9 width", sck_tick, 0);
            end
            run_en = 1'b0;
        end

        // R7: run low gives no ticks even at the fastest setting
        write_cfg(32'h0000_1000);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sck_tick) n++;
        end
        chk(n == 0, "R7 idle ticks", n, 0);

        // R7: drop mid-period, first tick after restart is full length
        write_cfg(32'h0000_1013);
        run_en = 1'b1;
        repeat (7) @(negedge clk);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        run_en = 1'b1;
        wait_tick(n);
        chk(n == 20, "R7 restart length", n, 20);

        // R8: write while running restarts with the new length
        write_cfg(32'h0000_101D);
        repeat (10) @(negedge clk);
        write_cfg(32'h0000_1009);
        chk(sck_tick == 1'b0, "R8 write edge", sck_tick, 0);
        wait_tick(n);
        chk(n == 10, "R8 new length", n, 10);

        // R8: write lands exactly on the edge where a tick is due
        write_cfg(32'h0000_1005);
        wait_tick(n);
        chk(n == 6, "R8 pre-collision period", n, 6);
        repeat (4) @(negedge clk);
        write_cfg(32'h0000_1002);
        chk(sck_tick == 1'b0, "R8 collision suppressed", sck_tick, 0);
        wait_tick(n);
        chk(n == 3, "R8 collision new length", n, 3);
        run_en = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule